// File: doc/BRIEF.md
# Fused multiply-add NaN selector

This unit decides which operand a fused multiply-add (a*b)+c forwards when one or more of its inputs is a NaN. It takes a 2-bit class code for each of the three operands, a flag saying that the product is an infinity times a zero, and a policy code. It returns a 2-bit choice naming operand a, b or c, or the default NaN, together with an invalid-operation flag. Operand values, the quieting of a signaling NaN and the arithmetic itself belong to the surrounding datapath.

Each policy is a family of processor conventions. They differ in the order in which operands are searched for a NaN, in whether signaling NaNs outrank quiet ones, and in how the infinity-times-zero product is resolved. The inputs are sampled when `valid_i` is high, and the choice and the flag appear one cycle later with `valid_o`.

Top module: `fma_nan_sel`

## Requirements
- R1: Class codes are 2'b00 for a non-NaN, 2'b01 for a quiet NaN and 2'b10 for a signaling NaN. The code 2'b11 counts as a non-NaN. The choice codes are 0 = a, 1 = b, 2 = c and 3 = default NaN.
- R2: The outputs are registered. `valid_o` equals `valid_i` delayed by one cycle. `sel_o` and `invalid_o` reflect the inputs that were sampled on the edge where `valid_i` was high.
- R3: Policy 0: if the inf-times-zero flag is set and c is a quiet NaN, `invalid_o` is 1 and the choice is 3. In every other case, `invalid_o` is 0 and the search order is signaling c, signaling a, signaling b, quiet c, quiet a, and b when nothing earlier matches.
- R4: Policy 1: any inf-times-zero sets `invalid_o` and selects 3. Otherwise the search takes signaling NaNs first in the order a, b, c, then quiet NaNs in the order a, b, c. When nothing matches, the choice is c.
- R5: Policy 2: inf-times-zero sets `invalid_o` and selects c. Otherwise the search order is the one used by policy 0.
- R6: Policy 3: inf-times-zero sets `invalid_o` and selects c. Otherwise the choice is a if a is any NaN, else c if c is any NaN, else b.
- R7: Policy values 4 and above use the fallback rule: a if a is any NaN, else b if b is any NaN, else c. `invalid_o` is 0 and the inf-times-zero flag is ignored.
- R8: While `valid_i` is low, `sel_o` and `invalid_o` keep their previous values. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Inputs are valid this cycle |
| policy_i | input | 3 | Policy code |
| cls_a_i | input | 2 | Class of operand a |
| cls_b_i | input | 2 | Class of operand b |
| cls_c_i | input | 2 | Class of operand c |
| infzero_i | input | 1 | Product is an infinity times a zero |
| valid_o | output | 1 | Result is valid |
| sel_o | output | 2 | Choice: 0 = a, 1 = b, 2 = c, 3 = default NaN |
| invalid_o | output | 1 | Invalid-operation flag |

## Verification
On every cycle, the assertions check that the output valid follows the input valid, that the outputs hold while no request is present, and that the registered result follows the sampled request for several rules: the flag under each policy, the default-NaN choice under policy 1, the choice of c under policies 2 and 3 for an inf-times-zero product, and the absence of the flag under the fallback policy. The full priority chains cannot be shown by the assertions, because a property could only restate the selection logic. The bench covers them with an exhaustive sweep of every policy, class triple and flag value, checked against an independent reference model.

// File: rtl/fma_nan_sel_pkg.sv
package fma_nan_sel_pkg;
  localparam int unsigned CLS_W = 2;
  localparam int unsigned SEL_W = 2;
  localparam int unsigned POL_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_NUM  = 2'b00,
    CLS_QNAN = 2'b01,
    CLS_SNAN = 2'b10,
    CLS_RSV  = 2'b11
  } cls_e;

  typedef enum logic [SEL_W-1:0] {
    PICK_A   = 2'd0,
    PICK_B   = 2'd1,
    PICK_C   = 2'd2,
    PICK_DEF = 2'd3
  } pick_e;

  typedef struct packed {
    logic sn;
    logic qn;
  } nan_bits_t;

  typedef struct packed {
    pick_e sel;
    logic  inv;
  } decision_t;
endpackage

// File: rtl/fma_nan_decode.sv
module fma_nan_decode
  import fma_nan_sel_pkg::*;
(
  input  logic [CLS_W-1:0] cls_i,
  output nan_bits_t        bits_o
);
  always_comb begin
    bits_o.sn = (cls_i == CLS_SNAN);
    bits_o.qn = (cls_i == CLS_QNAN);
  end
endmodule

// File: rtl/fma_nan_policy.sv
module fma_nan_policy
  import fma_nan_sel_pkg::*;
(
  input  logic [POL_W-1:0] policy_i,
  input  nan_bits_t        a_i,
  input  nan_bits_t        b_i,
  input  nan_bits_t        c_i,
  input  logic             infzero_i,
  output decision_t        dec_o
);
  logic a_any, b_any, c_any;
  pick_e chain_cab, chain_abc, first_acb, first_abc;

  always_comb begin
    a_any = a_i.sn | a_i.qn;
    b_any = b_i.sn | b_i.qn;
    c_any = c_i.sn | c_i.qn;

    // signaling c,a,b then quiet c,a, else b
    if      (c_i.sn) chain_cab = PICK_C;
    else if (a_i.sn) chain_cab = PICK_A;
    else if (b_i.sn) chain_cab = PICK_B;
    else if (c_i.qn) chain_cab = PICK_C;
    else if (a_i.qn) chain_cab = PICK_A;
    else             chain_cab = PICK_B;

    // signaling a,b,c then quiet a,b, else c
    if      (a_i.sn) chain_abc = PICK_A;
    else if (b_i.sn) chain_abc = PICK_B;
    else if (c_i.sn) chain_abc = PICK_C;
    else if (a_i.qn) chain_abc = PICK_A;
    else if (b_i.qn) chain_abc = PICK_B;
    else             chain_abc = PICK_C;

    if      (a_any) first_acb = PICK_A;
    else if (c_any) first_acb = PICK_C;
    else            first_acb = PICK_B;

    if      (a_any) first_abc = PICK_A;
    else if (b_any) first_abc = PICK_B;
    else            first_abc = PICK_C;

    dec_o = '{sel: first_abc, inv: 1'b0};
    unique case (policy_i)
      3'd0: dec_o = (infzero_i && c_i.qn) ? '{sel: PICK_DEF, inv: 1'b1}
                                          : '{sel: chain_cab, inv: 1'b0};
      3'd1: dec_o = infzero_i ? '{sel: PICK_DEF, inv: 1'b1}
                              : '{sel: chain_abc, inv: 1'b0};
      3'd2: dec_o = infzero_i ? '{sel: PICK_C, inv: 1'b1}
                              : '{sel: chain_cab, inv: 1'b0};
      3'd3: dec_o = infzero_i ? '{sel: PICK_C, inv: 1'b1}
                              : '{sel: first_acb, inv: 1'b0};
      default: dec_o = '{sel: first_abc, inv: 1'b0};
    endcase
  end
endmodule

// File: rtl/fma_nan_sel.sv
module fma_nan_sel
  import fma_nan_sel_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [POL_W-1:0] policy_i,
  input  logic [CLS_W-1:0] cls_a_i,
  input  logic [CLS_W-1:0] cls_b_i,
  input  logic [CLS_W-1:0] cls_c_i,
  input  logic             infzero_i,
  output logic             valid_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             invalid_o
);
  localparam int unsigned N_OPS = 3;

  logic [N_OPS-1:0][CLS_W-1:0] cls_vec;
  nan_bits_t [N_OPS-1:0]       bits;
  decision_t                   dec;
  decision_t                   dec_q;
  logic                        valid_q;

  assign cls_vec = {cls_c_i, cls_b_i, cls_a_i};

  for (genvar g = 0; g < N_OPS; g++) begin : g_dec
    fma_nan_decode u_dec (.cls_i(cls_vec[g]), .bits_o(bits[g]));
  end

  fma_nan_policy u_pol (
    .policy_i (policy_i),
    .a_i      (bits[0]),
    .b_i      (bits[1]),
    .c_i      (bits[2]),
    .infzero_i(infzero_i),
    .dec_o    (dec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      dec_q   <= '{sel: PICK_A, inv: 1'b0};
    end else begin
      valid_q <= valid_i;
      if (valid_i) dec_q <= dec;
    end
  end

  assign valid_o   = valid_q;
  assign sel_o     = dec_q.sel;
  assign invalid_o = dec_q.inv;
endmodule

// File: rtl/fma_nan_sel_chk.sv
module fma_nan_sel_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic [2:0] policy_i,
  input logic [1:0] cls_c_i,
  input logic       infzero_i,
  input logic       valid_o,
  input logic [1:0] sel_o,
  input logic       invalid_o
);
  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_valid_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(sel_o) && $stable(invalid_o)));
  a_r4_def_on_infzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && policy_i == 3'd1 && infzero_i) |=> (sel_o == 2'd3 && invalid_o));
  a_r5_r6_pick_c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (policy_i == 3'd2 || policy_i == 3'd3) && infzero_i)
      |=> (sel_o == 2'd2 && invalid_o));
  a_r3_inv_rule: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && policy_i == 3'd0) |=> (invalid_o == $past(infzero_i && cls_c_i == 2'b01)));
  a_r7_no_inv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && policy_i >= 3'd4) |=> !invalid_o);
  a_r3_no_default_without_inv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && sel_o == 2'd3) |-> invalid_o);
endmodule

bind fma_nan_sel fma_nan_sel_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .policy_i (policy_i),
  .cls_c_i  (cls_c_i),
  .infzero_i(infzero_i),
  .valid_o  (valid_o),
  .sel_o    (sel_o),
  .invalid_o(invalid_o)
);

// File: tb/fma_nan_sel_test.sv
module fma_nan_sel_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid_i = 1'b0;
  logic [2:0] policy = '0;
  logic [1:0] ca = '0, cb = '0, cc = '0;
  logic       iz = 1'b0;
  logic       valid_o;
  logic [1:0] sel_o;
  logic       invalid_o;

  int checks = 0;
  int errors = 0;
  logic       exp_valid = 1'b0;
  logic [1:0] exp_sel = '0;
  logic       exp_inv = 1'b0;

  always #10 clk = ~clk;

  fma_nan_sel uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .policy_i(policy),
    .cls_a_i(ca), .cls_b_i(cb), .cls_c_i(cc), .infzero_i(iz),
    .valid_o(valid_o), .sel_o(sel_o), .invalid_o(invalid_o)
  );

  function automatic bit is_s(logic [1:0] k); return k == 2'b10; endfunction
  function automatic bit is_q(logic [1:0] k); return k == 2'b01; endfunction
  function automatic bit is_n(logic [1:0] k); return is_s(k) || is_q(k); endfunction

  // reference: returns {inv, sel}
  function automatic logic [2:0] model(int p, logic [1:0] a, logic [1:0] b,
                                       logic [1:0] c, bit z);
    int order_s[$];
    int order_q[$];
    logic [1:0] cl[3];
    cl[0] = a; cl[1] = b; cl[2] = c;
    case (p)
      0: begin
        if (z && is_q(c)) return {1'b1, 2'd3};
        order_s = '{2, 0, 1}; order_q = '{2, 0};
        foreach (order_s[i]) if (is_s(cl[order_s[i]])) return {1'b0, 2'(order_s[i])};
        foreach (order_q[i]) if (is_q(cl[order_q[i]])) return {1'b0, 2'(order_q[i])};
        return {1'b0, 2'd1};
      end
      1: begin
        if (z) return {1'b1, 2'd3};
        for (int i = 0; i < 3; i++) if (is_s(cl[i])) return {1'b0, 2'(i)};
        for (int i = 0; i < 2; i++) if (is_q(cl[i])) return {1'b0, 2'(i)};
        return {1'b0, 2'd2};
      end
      2: begin
        if (z) return {1'b1, 2'd2};
        order_s = '{2, 0, 1}; order_q = '{2, 0};
        foreach (order_s[i]) if (is_s(cl[order_s[i]])) return {1'b0, 2'(order_s[i])};
        foreach (order_q[i]) if (is_q(cl[order_q[i]])) return {1'b0, 2'(order_q[i])};
        return {1'b0, 2'd1};
      end
      3: begin
        if (z) return {1'b1, 2'd2};
        if (is_n(a)) return {1'b0, 2'd0};
        if (is_n(c)) return {1'b0, 2'd2};
        return {1'b0, 2'd1};
      end
      default: begin
        if (is_n(a)) return {1'b0, 2'd0};
        if (is_n(b)) return {1'b0, 2'd1};
        return {1'b0, 2'd2};
      end
    endcase
  endfunction

  function automatic string req_of(int p);
    case (p)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string req);
    checks++;
    if (valid_o !== exp_valid || sel_o !== exp_sel || invalid_o !== exp_inv) begin
      errors++;
      $display("FAIL %s: got v=%0b sel=%0d inv=%0b exp v=%0b sel=%0d inv=%0b",
               req, valid_o, sel_o, invalid_o, exp_valid, exp_sel, exp_inv);
    end
  endtask

  // drive on the falling edge, model updates at the rising edge, check before next
  task automatic step(bit v, int p, logic [1:0] a, logic [1:0] b, logic [1:0] c,
                      bit z, string req);
    logic [2:0] r;
    @(negedge clk);
    valid_i = v; policy = 3'(p); ca = a; cb = b; cc = c; iz = z;
    @(posedge clk);
    exp_valid = v;
    if (v) begin
      r = model(p, a, b, c, z);
      exp_sel = r[1:0];
      exp_inv = r[2];
    end
    #5;
    check(req);
  endtask

  initial begin : watchdog
    #3ms;
    errors++;
    $display("FAIL watchdog: got hang exp finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #35;
    check("R8 reset");
    rst_n = 1'b1;
    // R1 R3..R7: exhaustive sweep of policies, classes (including 2'b11) and flag
    for (int p = 0; p < 8; p++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
          for (int c = 0; c < 4; c++)
            for (int z = 0; z < 2; z++)
              step(1'b1, p, 2'(a), 2'(b), 2'(c), z[0], req_of(p));
    // R8 hold: idle cycles with changing inputs must not alter outputs
    step(1'b1, 1, 2'b10, 2'b00, 2'b00, 1'b1, "R4");
    step(1'b0, 0, 2'b01, 2'b01, 2'b01, 1'b0, "R8 hold");
    step(1'b0, 4, 2'b00, 2'b00, 2'b00, 1'b0, "R8 hold");
    // R2 back-to-back and gap
    step(1'b1, 0, 2'b01, 2'b10, 2'b00, 1'b0, "R2");
    step(1'b1, 3, 2'b00, 2'b00, 2'b01, 1'b0, "R2");
    step(1'b0, 2, 2'b10, 2'b10, 2'b10, 1'b1, "R2 R8");
    step(1'b1, 7, 2'b00, 2'b00, 2'b00, 1'b1, "R7");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule